// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Unit

This unit makes the issue decision for a two-slot in-order pipeline. Every fetched packet is 64-bit aligned and carries two instructions. The first word is the ALU/branch slot and the second word is the load/store slot, and an unused slot holds a nop. While a packet sits in decode, the unit compares its register fields against two things: the load that currently occupies execute, and the packet's own ALU destination. From these comparisons it decides whether the packet moves on whole, stalls whole, or is split so that the load/store half leaves one cycle after its ALU partner.

When the unit raises `stall_o`, the surrounding pipeline holds the fetch PC and the decode register. Each of the two issue outputs selects either the decoded instruction or a nop for the matching execute slot. An ALU result needed by the next packet is forwarded, so it never causes a stall. The unit itself keeps one bit of state, which records that it is in the second cycle of a split. In that cycle only the held load/store instruction is checked and issued.

Top module: `dual_issue_hazard_unit`

## Requirements
- R1: After reset, and with `pkt_valid_i` low in the normal phase, `stall_o`, `alu_issue_o`, `ls_issue_o` and `split_hold_o` are all 0.
- R2: A valid packet with no dependency issues both slots in one cycle: `stall_o`=0, `alu_issue_o`=1, `ls_issue_o`=1.
- R3: A load in execute (`ex_load_i`=1) whose destination equals a used source of the ALU slot gives `stall_o`=1 with both issue outputs at 0 (a bubble of two nops).
- R4: A load in execute whose destination equals a used source of the load/store slot stalls the whole packet in the same way as R3.
- R5: Register 0 never creates a dependency, whether it is the execute destination or the ALU slot destination.
- R6: If the load/store slot reads the ALU slot's destination, the first cycle gives `stall_o`=1, `alu_issue_o`=1, `ls_issue_o`=0. The next cycle gives `stall_o`=0, `alu_issue_o`=0, `ls_issue_o`=1 and `split_hold_o`=1.
- R7: A non-load in execute (`ex_load_i`=0) never stalls the packet, even when its destination matches a source.
- R8: When a load-use stall and an in-packet split both apply, the load-use stall comes first. The split follows once the load-use stall has cleared.
- R9: A source whose use flag is 0 is never compared, and an ALU destination whose write flag is 0 never causes a split.
- R10: In the second cycle of a split, a load in execute that matches a used source of the held load/store instruction gives `stall_o`=1 with both issue outputs at 0, and `split_hold_o` stays 1. The ALU slot's sources are not checked in that cycle.
- R11: An asynchronous reset during a split returns the unit to the normal phase (`split_hold_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Decode register holds a packet |
| alu_rs1_i | input | REG_AW | ALU slot first source |
| alu_rs1_use_i | input | 1 | ALU slot reads first source |
| alu_rs2_i | input | REG_AW | ALU slot second source |
| alu_rs2_use_i | input | 1 | ALU slot reads second source |
| alu_rd_i | input | REG_AW | ALU slot destination |
| alu_rd_we_i | input | 1 | ALU slot writes its destination |
| ls_rs1_i | input | REG_AW | Load/store slot base register |
| ls_rs1_use_i | input | 1 | Load/store slot reads base register |
| ls_rs2_i | input | REG_AW | Load/store slot store-data register |
| ls_rs2_use_i | input | 1 | Load/store slot reads store-data register |
| ex_rd_i | input | REG_AW | Destination of the load/store slot in execute |
| ex_load_i | input | 1 | Execute load/store slot is a load |
| stall_o | output | 1 | Hold fetch PC and decode register |
| alu_issue_o | output | 1 | 1: pass ALU slot to execute, 0: nop |
| ls_issue_o | output | 1 | 1: pass load/store slot to execute, 0: nop |
| split_hold_o | output | 1 | Second cycle of a split packet |

## Verification
The hardest situation to reach from the ports is a load-use hit that falls on the second cycle of a split (R10). In that cycle the unit must stall only on the held load/store sources and must stay in the hold phase. The bench gets there by first applying a packet with an in-packet dependency and then, on the following cycle, raising `ex_load_i` with a destination that matches the store-data register. It also sets the ALU slot sources so they match a second load, which confirms those sources are ignored in that phase. The priority case (R8) is reached in a similar way: a packet that needs a split is presented while a matching load sits in execute, and the load is then removed cycle by cycle.

// File: rtl/hiu_pkg.sv
package hiu_pkg;
  localparam int unsigned REG_AW_DEF = 5;
  localparam int unsigned NSRC       = 2;

  typedef enum logic {
    PH_NORMAL = 1'b0,
    PH_HOLD   = 1'b1
  } phase_e;
endpackage

// File: rtl/hiu_src_match.sv
module hiu_src_match #(
  parameter int unsigned AW = 5,
  parameter int unsigned N  = 2
) (
  input  logic [N-1:0][AW-1:0] src_i,
  input  logic [N-1:0]         used_i,
  input  logic [AW-1:0]        dst_i,
  input  logic                 dst_vld_i,
  output logic                 hit_o
);
  logic [N-1:0] eq;
  logic         dst_live;

  // register 0 is hardwired and carries no dependency
  assign dst_live = dst_vld_i && (dst_i != '0);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = dst_live && used_i[g] && (src_i[g] == dst_i);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/hiu_issue_ctrl.sv
module hiu_issue_ctrl
  import hiu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pkt_valid_i,
  input  logic luse_alu_i,
  input  logic luse_ls_i,
  input  logic intra_i,
  output logic stall_o,
  output logic alu_issue_o,
  output logic ls_issue_o,
  output logic hold_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d        = ph_q;
    stall_o     = 1'b0;
    alu_issue_o = 1'b0;
    ls_issue_o  = 1'b0;
    unique case (ph_q)
      PH_NORMAL: begin
        if (pkt_valid_i) begin
          if (luse_alu_i || luse_ls_i) begin
            stall_o = 1'b1;
          end else if (intra_i) begin
            stall_o     = 1'b1;
            alu_issue_o = 1'b1;
            ph_d        = PH_HOLD;
          end else begin
            alu_issue_o = 1'b1;
            ls_issue_o  = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        // ALU half already left; only the held load/store is checked
        if (luse_ls_i) begin
          stall_o = 1'b1;
        end else begin
          ls_issue_o = 1'b1;
          ph_d       = PH_NORMAL;
        end
      end
      default: ph_d = PH_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_NORMAL;
    else         ph_q <= ph_d;
  end

  assign hold_o = (ph_q == PH_HOLD);

  a_r3_luse_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && pkt_valid_i && luse_alu_i) |-> (stall_o && !alu_issue_o && !ls_issue_o));
  a_r4_luse_ls_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && luse_ls_i) |-> (stall_o && !alu_issue_o && !ls_issue_o));
  a_r6_split_enters_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && alu_issue_o && !ls_issue_o) |=> hold_o);
  a_r6_hold_no_alu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !alu_issue_o);
  a_r8_luse_before_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && pkt_valid_i && luse_alu_i && intra_i) |=> !hold_o);
  a_r10_hold_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && stall_o) |=> hold_o);
  a_r2_go_means_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && pkt_valid_i && !stall_o) |-> (alu_issue_o && ls_issue_o));
endmodule

// File: rtl/dual_issue_hazard_unit.sv
module dual_issue_hazard_unit
  import hiu_pkg::*;
#(
  parameter int unsigned REG_AW = REG_AW_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  input  logic [REG_AW-1:0] alu_rs1_i,
  input  logic              alu_rs1_use_i,
  input  logic [REG_AW-1:0] alu_rs2_i,
  input  logic              alu_rs2_use_i,
  input  logic [REG_AW-1:0] alu_rd_i,
  input  logic              alu_rd_we_i,
  input  logic [REG_AW-1:0] ls_rs1_i,
  input  logic              ls_rs1_use_i,
  input  logic [REG_AW-1:0] ls_rs2_i,
  input  logic              ls_rs2_use_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_load_i,
  output logic              stall_o,
  output logic              alu_issue_o,
  output logic              ls_issue_o,
  output logic              split_hold_o
);
  logic [NSRC-1:0][REG_AW-1:0] alu_src, ls_src;
  logic [NSRC-1:0]             alu_use, ls_use;
  logic luse_alu, luse_ls, intra;

  assign alu_src = {alu_rs2_i, alu_rs1_i};
  assign alu_use = {alu_rs2_use_i, alu_rs1_use_i};
  assign ls_src  = {ls_rs2_i, ls_rs1_i};
  assign ls_use  = {ls_rs2_use_i, ls_rs1_use_i};

  hiu_src_match #(.AW(REG_AW), .N(NSRC)) u_luse_alu (
    .src_i(alu_src), .used_i(alu_use), .dst_i(ex_rd_i), .dst_vld_i(ex_load_i),
    .hit_o(luse_alu));

  hiu_src_match #(.AW(REG_AW), .N(NSRC)) u_luse_ls (
    .src_i(ls_src), .used_i(ls_use), .dst_i(ex_rd_i), .dst_vld_i(ex_load_i),
    .hit_o(luse_ls));

  hiu_src_match #(.AW(REG_AW), .N(NSRC)) u_intra (
    .src_i(ls_src), .used_i(ls_use), .dst_i(alu_rd_i), .dst_vld_i(alu_rd_we_i),
    .hit_o(intra));

  hiu_issue_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .pkt_valid_i(pkt_valid_i),
    .luse_alu_i(luse_alu), .luse_ls_i(luse_ls), .intra_i(intra),
    .stall_o(stall_o), .alu_issue_o(alu_issue_o), .ls_issue_o(ls_issue_o),
    .hold_o(split_hold_o));

  a_r5_r0_no_luse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i == '0) |-> (!luse_alu && !luse_ls));
  a_r5_r0_no_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_rd_i == '0) |-> !intra);
  a_r7_alu_fwd_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_load_i && !split_hold_o && !intra) |-> !stall_o);
  a_r9_unused_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ls_rs1_use_i && !ls_rs2_use_i) |-> (!intra && !luse_ls));
endmodule

// File: tb/dual_issue_hazard_unit_test.sv
module dual_issue_hazard_unit_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 5;

  typedef struct packed {
    logic [3:0]    req;
    logic          v;
    logic [AW-1:0] a1; logic u1;
    logic [AW-1:0] a2; logic u2;
    logic [AW-1:0] ad; logic aw;
    logic [AW-1:0] l1; logic lu1;
    logic [AW-1:0] l2; logic lu2;
    logic [AW-1:0] er; logic el;
    logic es; logic ea; logic elo;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b1, 5'd6,1'b1, 1'b0,1'b1,1'b1}, // R2
    '{4'd3, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b1, 5'd1,1'b1, 1'b1,1'b0,1'b0}, // R3 rs1
    '{4'd3, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b1, 5'd2,1'b1, 1'b1,1'b0,1'b0}, // R3 rs2
    '{4'd4, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b1, 5'd4,1'b1, 1'b1,1'b0,1'b0}, // R4 base
    '{4'd4, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b1, 5'd5,1'b1, 1'b1,1'b0,1'b0}, // R4 store data
    '{4'd9, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b0, 5'd5,1'b1, 1'b0,1'b1,1'b1}, // R9 unused ls src
    '{4'd7, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b1, 5'd1,1'b0, 1'b0,1'b1,1'b1}, // R7 alu in ex
    '{4'd5, 1'b1, 5'd0,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b1, 5'd0,1'b1, 1'b0,1'b1,1'b1}, // R5 ex r0
    '{4'd5, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd0,1'b1, 5'd0,1'b1, 5'd5,1'b1, 5'd6,1'b1, 1'b0,1'b1,1'b1}, // R5 alu rd r0
    '{4'd9, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd4,1'b0, 5'd4,1'b1, 5'd5,1'b1, 5'd6,1'b1, 1'b0,1'b1,1'b1}, // R9 no write
    '{4'd1, 1'b0, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b1, 5'd1,1'b1, 1'b0,1'b0,1'b0}, // R1 no packet
    '{4'd9, 1'b1, 5'd1,1'b0, 5'd2,1'b1, 5'd3,1'b1, 5'd4,1'b1, 5'd5,1'b1, 5'd1,1'b1, 1'b0,1'b1,1'b1}  // R9 unused alu src
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pkt_valid = 1'b0;
  logic [AW-1:0] a1 = '0, a2 = '0, ad = '0, l1 = '0, l2 = '0, er = '0;
  logic u1 = 1'b0, u2 = 1'b0, aw = 1'b0, lu1 = 1'b0, lu2 = 1'b0, el = 1'b0;
  logic stall, alu_iss, ls_iss, hold;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_hazard_unit #(.REG_AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pkt_valid_i(pkt_valid),
    .alu_rs1_i(a1), .alu_rs1_use_i(u1), .alu_rs2_i(a2), .alu_rs2_use_i(u2),
    .alu_rd_i(ad), .alu_rd_we_i(aw),
    .ls_rs1_i(l1), .ls_rs1_use_i(lu1), .ls_rs2_i(l2), .ls_rs2_use_i(lu2),
    .ex_rd_i(er), .ex_load_i(el),
    .stall_o(stall), .alu_issue_o(alu_iss), .ls_issue_o(ls_iss), .split_hold_o(hold));

  task automatic drive(input vec_t v);
    pkt_valid = v.v;
    a1 = v.a1; u1 = v.u1; a2 = v.a2; u2 = v.u2; ad = v.ad; aw = v.aw;
    l1 = v.l1; lu1 = v.lu1; l2 = v.l2; lu2 = v.lu2; er = v.er; el = v.el;
  endtask

  task automatic chk(input string req, input logic es, input logic ea,
                     input logic elo, input logic eh);
    total++;
    if ({stall, alu_iss, ls_iss, hold} !== {es, ea, elo, eh}) begin
      bad++;
      $display("FAIL %s: stall/alu/ls/hold got %b%b%b%b exp %b%b%b%b",
               req, stall, alu_iss, ls_iss, hold, es, ea, elo, eh);
    end
  endtask

  // split packet: alu writes r3, ls base reads r3
  localparam vec_t SPLIT = '{4'd6, 1'b1, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1, 5'd3,1'b1, 5'd5,1'b1, 5'd9,1'b0, 1'b1,1'b1,1'b0};
  localparam vec_t PLAIN = '{4'd2, 1'b1, 5'd10,1'b1, 5'd11,1'b1, 5'd12,1'b1, 5'd13,1'b1, 5'd14,1'b1, 5'd9,1'b0, 1'b0,1'b1,1'b1};

  initial begin
    vec_t v;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_ni = 1'b1; #1;
    chk("R1", 1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]); #1;
      chk($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].es, VEC[i].ea, VEC[i].elo, 1'b0);
    end

    // R6 split then held load/store
    @(negedge clk); drive(SPLIT); #1;
    chk("R6 first", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk("R6 second", 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); drive(PLAIN); #1;
    chk("R6 after", 1'b0, 1'b1, 1'b1, 1'b0);

    // R8 load-use and split together
    @(negedge clk); v = SPLIT; v.er = 5'd1; v.el = 1'b1; drive(v); #1;
    chk("R8 luse first", 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); el = 1'b0; #1;
    chk("R8 then split", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk("R8 then held", 1'b0, 1'b0, 1'b1, 1'b1);

    // R10 load-use hit on held store data; ALU sources ignored
    @(negedge clk); drive(SPLIT); #1;
    chk("R10 split", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); er = 5'd5; el = 1'b1; #1;
    chk("R10 held stall", 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk); er = 5'd1; el = 1'b1; #1;
    chk("R10 alu src ignored", 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); drive(PLAIN); #1;
    chk("R10 back normal", 1'b0, 1'b1, 1'b1, 1'b0);

    // R11 reset during split
    @(negedge clk); drive(SPLIT); #1;
    chk("R11 split", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk("R11 held", 1'b0, 1'b0, 1'b1, 1'b1);
    rst_ni = 1'b0; pkt_valid = 1'b0; #1;
    chk("R11 reset", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_ni = 1'b1; drive(PLAIN); #1;
    chk("R11 resume", 1'b0, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung exp done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule